// File: doc/BRIEF.md
# Running-Sum Moving Average Filter

This block smooths a stream of unsigned converter samples with a moving average built from two stages: a running accumulator (integrator) followed by a difference against an older accumulator value (comb). Each accepted sample is widened by placing it above four zero guard bits, which multiplies it by 16. The widened sample is added into the accumulator. The comb then subtracts the accumulator value from `WINDOW` accepted samples earlier, which gives the sum over the window. The block does not need one adder per tap.

A producer presents a sample with `inValid` high for one cycle. One cycle later the filtered result appears on `outSample` with `outValid` high. Cycles with `inValid` low leave all state untouched. A parameter chooses which 24-bit slice of the 28-bit window sum reaches the output:

- The upper slice gives the plain sum of the samples in the window, reduced modulo 2^24.
- The lower slice gives sixteen times that sum, reduced modulo 2^24. It keeps the guard resolution but overflows sooner.

Top module: `movavg_filter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `outValid` low and `outSample` to zero on the next cycle. It also clears the accumulator and every stored history value, so the result after reset depends only on samples accepted after it.
- R2: `outValid` is high in exactly the cycles that follow an edge where `inValid` was high and `rst` low. In all other cycles it is low.
- R3: An edge with `inValid` low changes neither `outSample` nor any internal state. Idle cycles between samples do not alter later results.
- R4: Each 24-bit sample enters the datapath as its value times 16: the sample sits in bits 27:4 of the internal word and bits 3:0 are zero.
- R5: After reset, the k-th accepted sample (k ≤ `WINDOW`) produces the partial sum of all k samples accepted so far.
- R6: Once more than `WINDOW` samples have been accepted, the output reflects exactly the most recent `WINDOW` samples. Older samples no longer contribute.
- R7: With `UPPER_SLICE`=1 (the default), `outSample` equals the sum of the samples in the window modulo 2^24.
- R8: All integrator and comb arithmetic wraps modulo 2^28. A long run of full-scale samples, which rolls the accumulator over repeatedly, still yields the correct window sum, for example 16 × 0xFFFFFF mod 2^24 = 0xFFFFF0 with `WINDOW`=16.
- R9: With `UPPER_SLICE`=0, `outSample` equals 16 times the window sum modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample on `inSample` is accepted this cycle |
| inSample | input | SAMPLE_W (24) | Unsigned input sample |
| outValid | output | 1 | `outSample` carries a new result |
| outSample | output | SAMPLE_W (24) | Selected 24-bit slice of the window sum |

## Verification
The assertions assume that `rst` is held high from time zero through the first clock edge. They also assume that `inValid` and `inSample` are known and change only away from the rising edge. The bench meets this by driving every input on the falling edge and asserting reset before the first rising edge. The bench's reference model is exact only when `WINDOW` equals the bench's model depth of 16. Stimulus also includes long runs of full-scale samples, so the modulo arithmetic is covered rather than assumed.

// File: rtl/movavg_pkg.sv
package movavg_pkg;
  // Strobes from the control section to the datapath
  typedef struct packed {
    logic advance;  // accept a sample this cycle
    logic clear;    // synchronous clear of all state
  } mavgStrobe_t;
endpackage

// File: rtl/movavg_ctrl.sv
module movavg_ctrl
  import movavg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output mavgStrobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.clear   = rst;
    strobe.advance = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R2: a result follows each accepted sample, and only those
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R1: reset leaves no result pending
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !outValid);
endmodule

// File: rtl/movavg_datapath.sv
module movavg_datapath
  import movavg_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int GUARD_W     = 4,
  parameter int WINDOW      = 16,
  parameter bit UPPER_SLICE = 1'b1
)(
  input  logic                clk,
  input  logic                rst,
  input  mavgStrobe_t         strobe,
  input  logic [SAMPLE_W-1:0] inSample,
  output logic [SAMPLE_W-1:0] outSample
);
  localparam int ACC_W = SAMPLE_W + GUARD_W;
  localparam int PTR_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(WINDOW - 1);

  logic [ACC_W-1:0]    integ;
  logic [ACC_W-1:0]    history [WINDOW];
  logic [PTR_W-1:0]    slotPtr;
  logic [ACC_W-1:0]    widened;
  logic [ACC_W-1:0]    integNext;
  logic [ACC_W-1:0]    combDiff;
  logic [SAMPLE_W-1:0] sliceVal;

  // R4: sample placed above the zero guard bits
  assign widened   = {inSample, {GUARD_W{1'b0}}};
  // R8: both stages wrap modulo 2^ACC_W
  assign integNext = integ + widened;
  assign combDiff  = integNext - history[slotPtr];

  generate
    if (UPPER_SLICE) begin : g_upper
      assign sliceVal = combDiff[ACC_W-1:GUARD_W];
    end else begin : g_lower
      assign sliceVal = combDiff[SAMPLE_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      integ     <= '0;
      slotPtr   <= '0;
      outSample <= '0;
      for (int i = 0; i < WINDOW; i++) history[i] <= '0;
    end else if (strobe.advance) begin
      integ            <= integNext;
      history[slotPtr] <= integNext;
      outSample        <= sliceVal;
      slotPtr          <= (slotPtr == LAST_SLOT) ? '0 : slotPtr + 1'b1;
    end
  end

  // R3: idle cycles leave the state alone
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !strobe.advance && !strobe.clear |=> $stable(integ) && $stable(outSample) && $stable(slotPtr));
  // R4: the accumulator grows by sixteen times the accepted sample
  assert_integ_step_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.advance |=> integ == $past(integ) + ACC_W'({$past(inSample), {GUARD_W{1'b0}}}));
  // R6: history pointer never leaves the window
  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (rst)
    slotPtr <= LAST_SLOT);
  // R1: reset clears the output and accumulator
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> outSample == '0 && integ == '0);
endmodule

// File: rtl/movavg_filter.sv
module movavg_filter
  import movavg_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int GUARD_W     = 4,
  parameter int WINDOW      = 16,
  parameter bit UPPER_SLICE = 1'b1
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outSample
);
  mavgStrobe_t strobe;

  movavg_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  movavg_datapath #(
    .SAMPLE_W    (SAMPLE_W),
    .GUARD_W     (GUARD_W),
    .WINDOW      (WINDOW),
    .UPPER_SLICE (UPPER_SLICE)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .inSample  (inSample),
    .outSample (outSample)
  );
endmodule

// File: tb/movavg_filter_test.sv
`timescale 1ns/1ps
module movavg_filter_test;
  localparam int W   = 24;
  localparam int WIN = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [W-1:0] inSample = '0;
  logic outValid, outValidLow;
  logic [W-1:0] outSample, outSampleLow;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [W-1:0] model [WIN];
  int modelIdx = 0;

  always #2 clk = ~clk;  // 250 MHz

  movavg_filter #(.WINDOW(WIN), .UPPER_SLICE(1'b1)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .outSample(outSample));

  movavg_filter #(.WINDOW(WIN), .UPPER_SLICE(1'b0)) uutLow (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outValid(outValidLow), .outSample(outSampleLow));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] windowSum();
    logic [63:0] s = 0;
    for (int i = 0; i < WIN; i++) s += 64'(model[i]);
    return s;
  endfunction

  task automatic doReset();
    @(negedge clk); rst = 1'b1; inValid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < WIN; i++) model[i] = '0;
    modelIdx = 0;
  endtask

  // Send one sample; check valid and both slices one cycle later
  task automatic sendSample(input logic [W-1:0] x, input string req);
    logic [63:0] s;
    @(negedge clk); inValid = 1'b1; inSample = x;
    @(negedge clk); inValid = 1'b0;
    model[modelIdx] = x; modelIdx = (modelIdx + 1) % WIN;
    s = windowSum();
    check({req, " R2 valid"}, 64'(outValid), 64'd1);
    check({req, " R7 upper"}, 64'(outSample), 64'(s[W-1:0]));
    check({req, " R9 lower"}, 64'(outSampleLow), 64'(((s * 16) & 64'hFFFFFF)));
  endtask

  task automatic testReset();
    doReset();
    check("R1 valid after reset", 64'(outValid), 64'd0);
    check("R1 upper after reset", 64'(outSample), 64'd0);
    check("R1 lower after reset", 64'(outSampleLow), 64'd0);
  endtask

  task automatic testScaling();
    doReset();
    sendSample(24'h012345, "R4");
    check("R4 x16 on lower slice", 64'(outSampleLow), 64'h123450);
  endtask

  task automatic testPartial();
    doReset();
    for (int k = 1; k <= WIN; k++) sendSample(24'(k * 1000), "R5 partial");
    check("R5 full partial sum", 64'(outSample), 64'(136000));
  endtask

  task automatic testIdle();
    logic [W-1:0] held;
    doReset();
    for (int k = 0; k < 3; k++) sendSample(24'(k + 5), "R3 pre");
    held = outSample;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R3 idle valid low R2", 64'(outValid), 64'd0);
      check("R3 idle output held", 64'(outSample), 64'(held));
    end
    sendSample(24'd100, "R3 post");
  endtask

  task automatic testSteady();
    doReset();
    for (int k = 0; k < 40; k++) sendSample(24'(k * 24'h0A3B1 + 7), "R6 steady");
  endtask

  task automatic testWrap();
    doReset();
    for (int k = 0; k < 40; k++) sendSample(24'hFFFFFF, "R8 wrap");
    check("R8 full-scale window sum", 64'(outSample), 64'hFFFFF0);
  endtask

  task automatic testMidReset();
    doReset();
    for (int k = 0; k < 7; k++) sendSample(24'h00F00F, "R1 pre");
    doReset();
    sendSample(24'h000321, "R1 post");
    check("R1 history cleared", 64'(outSample), 64'h000321);
  endtask

  initial begin
    testReset();
    testScaling();
    testPartial();
    testIdle();
    testSteady();
    testWrap();
    testMidReset();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule